// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and owns the decision of when an interrupt is taken. It keeps a request bit and an enable bit for each maskable source, plus the global inhibit flag. It also latches a pending break request and a pending reset. The core pulses `insn_start` at each instruction boundary, and only there are maskable and break requests considered. A released reset starts its own entry at once.

Once a request wins, the block runs a fixed bus sequence on a simple byte-wide memory port:
- two idle pipeline cycles;
- three stack writes (program counter high byte, program counter low byte, status byte), each at the current stack address followed by a decrement;
- two reads of the handler address from consecutive vector locations.

The memory answers a read one cycle after it is issued. After the high byte arrives, the block pulses `pc_load` with the new program counter and the updated stack pointer. Reset entry skips the stack writes.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry starts only from an `insn_start` pulse given while idle, or from a pending reset. With requests pending and no `insn_start`, `busy` stays 0. An `insn_start` or `brk_strobe` seen while `busy`=1 does not extend or chain the running sequence.
- R2: Maskable source i is taken only when its request bit is 1, its enable bit (bit i of the last `en_wdata` written with `en_we`) is 1, and `iflag` is 0.
- R3: A pending break (latched from `brk_strobe`) is taken at the next boundary even when `iflag` is 1.
- R4: Priority among ready requests: reset first, then break, then the maskable source with the lowest index.
- R5: A non-reset entry keeps `busy` at 1 for 8 cycles, numbered 0 to 7:
  - cycles 0 and 1 carry no bus access;
  - cycles 2, 3 and 4 are writes;
  - cycle 5 reads the vector low address and cycle 6 reads the following address;
  - `bus_rd` and `bus_wr` are never 1 together.
- R6: Pushes go to `{STACK_PAGE, sp}`, then `sp-1`, then `sp-2`, where sp is `sp_in` at acceptance. They carry `pc_in[15:8]`, then `pc_in[7:0]`, then `ps_in`. At the end `sp_out` is sp-3 with `sp_load`=1.
- R7: On acceptance `iflag` becomes 1 and stays 1 while busy; `iflag_we` writes are ignored while busy. The serviced source's request bit is cleared, and other request bits are kept.
- R8: `pc_out` = {byte read at vector+1, byte read at vector}. `pc_load` is 1 for exactly one cycle, the first cycle with `busy`=0 after the entry.
- R9: Vector low addresses: reset at `VEC_TOP`, break at `VEC_TOP-2`, and maskable source i at `VEC_TOP-4-2*i`.
- R10: Reset entry:
  - `rst` clears all request and enable bits and sets `iflag` to 1;
  - after release, `busy` is 1 for 5 cycles, with reads of `VEC_TOP` and `VEC_TOP+1` in cycles 2 and 3 and no writes;
  - it ends with `pc_load`=1 and `sp_load`=0.
- R11: A source event sets its request bit, which stays set across boundaries while the source is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a reset entry |
| src_evt | input | NUM_SRC | One-cycle event pulses, one per maskable source |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_SRC | New enable bits |
| iflag_we | input | 1 | Write strobe for the inhibit flag (ignored while busy) |
| iflag_wdata | input | 1 | New inhibit flag value |
| insn_start | input | 1 | Instruction-boundary strobe from the core |
| brk_strobe | input | 1 | Break instruction request pulse |
| pc_in | input | 16 | Return address to push |
| ps_in | input | 8 | Status byte to push |
| sp_in | input | 8 | Stack pointer at acceptance |
| bus_rdata | input | 8 | Read data, valid the cycle after a read |
| bus_addr | output | 16 | Memory address |
| bus_wr | output | 1 | Write cycle |
| bus_rd | output | 1 | Read cycle |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | Entry sequence in progress |
| iflag | output | 1 | Inhibit flag |
| pc_out | output | 16 | Handler address |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` |
| sp_out | output | 8 | Stack pointer after pushes |
| sp_load | output | 1 | One-cycle strobe: load `sp_out` |

## Verification
The bench builds the block with NUM_SRC=4, VEC_TOP=16'hFFFE and STACK_PAGE=8'h01. With these values every vector slot, including the highest-index source, falls on distinct addresses the bench memory answers with a computed byte. Four sources are enough to show lowest-index priority with gaps and a masked high source. They also show a request that survives a masked boundary and a second source taken after the first has been cleared.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_BREAK = 2'd1,
    K_MASK  = 2'd2
  } req_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DMY1, S_DMY2, S_PUSH_H, S_PUSH_L, S_PUSH_S,
    S_VEC_L, S_VEC_H, S_FIN
  } seq_state_e;

  // distance below the top vector slot
  function automatic int vec_offset(req_kind_e k, int idx);
    case (k)
      K_RESET: return 0;
      K_BREAK: return 2;
      default: return 4 + 2 * idx;
    endcase
  endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] en
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        req[g] <= 1'b0;
        en[g]  <= 1'b0;
      end else begin
        // a fresh event outranks the clear of the serviced bit
        req[g] <= (req[g] & ~clr_mask[g]) | evt[g];
        if (en_we) en[g] <= en_wdata[g];
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               idle,
  input  logic               boundary,
  input  logic               rst_pend,
  input  logic               brk_pend,
  input  logic               iflag,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en,
  output logic               take,
  output req_kind_e          kind,
  output logic [IW-1:0]      idx
);
  logic [NUM_SRC-1:0] ready;
  logic               any_ready;

  assign ready     = req & en & {NUM_SRC{~iflag}};
  assign any_ready = |ready;

  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ready[i]) idx = IW'(i);
    end
  end

  always_comb begin
    take = 1'b0;
    kind = K_MASK;
    if (idle) begin
      if (rst_pend) begin
        take = 1'b1;
        kind = K_RESET;
      end else if (boundary && brk_pend) begin
        take = 1'b1;
        kind = K_BREAK;
      end else if (boundary && any_ready) begin
        take = 1'b1;
        kind = K_MASK;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int          NUM_SRC    = 4,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               iflag_we,
  input  logic               iflag_wdata,
  input  logic               insn_start,
  input  logic               brk_strobe,
  input  logic [15:0]        pc_in,
  input  logic [7:0]         ps_in,
  input  logic [7:0]         sp_in,
  input  logic [7:0]         bus_rdata,
  output logic [15:0]        bus_addr,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [7:0]         bus_wdata,
  output logic               busy,
  output logic               iflag,
  output logic [15:0]        pc_out,
  output logic               pc_load,
  output logic [7:0]         sp_out,
  output logic               sp_load
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  seq_state_e         state;
  req_kind_e          kind_r;
  req_kind_e          pick_kind;
  logic [IW-1:0]      pick_idx;
  logic               take;
  logic               rst_pend, brk_pend;
  logic [NUM_SRC-1:0] req, en, clr_mask;
  logic [15:0]        vec_r, pc_r, pick_vec;
  logic [7:0]         ps_r, sp_r, lo_r;

  assign busy     = (state != S_IDLE);
  assign pick_vec = VEC_TOP - 16'(vec_offset(pick_kind, int'(pick_idx)));

  always_comb begin
    clr_mask = '0;
    if (take && pick_kind == K_MASK) clr_mask[pick_idx] = 1'b1;
  end

  irq_req_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .evt(src_evt), .en_we(en_we), .en_wdata(en_wdata),
    .clr_mask(clr_mask), .req(req), .en(en)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .idle(state == S_IDLE), .boundary(insn_start), .rst_pend(rst_pend),
    .brk_pend(brk_pend), .iflag(iflag), .req(req), .en(en),
    .take(take), .kind(pick_kind), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind_r    <= K_RESET;
      rst_pend  <= 1'b1;
      brk_pend  <= 1'b0;
      iflag     <= 1'b1;
      bus_addr  <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wdata <= '0;
      pc_out    <= '0;
      pc_load   <= 1'b0;
      sp_out    <= '0;
      sp_load   <= 1'b0;
      vec_r     <= '0;
      pc_r      <= '0;
      ps_r      <= '0;
      sp_r      <= '0;
      lo_r      <= '0;
    end else begin
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
      pc_load <= 1'b0;
      sp_load <= 1'b0;
      if (brk_strobe) brk_pend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (iflag_we) iflag <= iflag_wdata;
          if (take) begin
            state  <= S_DMY1;
            iflag  <= 1'b1;
            kind_r <= pick_kind;
            vec_r  <= pick_vec;
            pc_r   <= pc_in;
            ps_r   <= ps_in;
            sp_r   <= sp_in;
            if (pick_kind == K_RESET) rst_pend <= 1'b0;
            if (pick_kind == K_BREAK) brk_pend <= 1'b0;
          end
        end
        S_DMY1: state <= S_DMY2;
        S_DMY2: begin
          if (kind_r == K_RESET) begin
            state    <= S_VEC_L;
            bus_rd   <= 1'b1;
            bus_addr <= vec_r;
          end else begin
            state     <= S_PUSH_H;
            bus_wr    <= 1'b1;
            bus_addr  <= {STACK_PAGE, sp_r};
            bus_wdata <= pc_r[15:8];
            sp_r      <= sp_r - 8'd1;
          end
        end
        S_PUSH_H: begin
          state     <= S_PUSH_L;
          bus_wr    <= 1'b1;
          bus_addr  <= {STACK_PAGE, sp_r};
          bus_wdata <= pc_r[7:0];
          sp_r      <= sp_r - 8'd1;
        end
        S_PUSH_L: begin
          state     <= S_PUSH_S;
          bus_wr    <= 1'b1;
          bus_addr  <= {STACK_PAGE, sp_r};
          bus_wdata <= ps_r;
          sp_r      <= sp_r - 8'd1;
        end
        S_PUSH_S: begin
          state    <= S_VEC_L;
          bus_rd   <= 1'b1;
          bus_addr <= vec_r;
        end
        S_VEC_L: begin
          state    <= S_VEC_H;
          bus_rd   <= 1'b1;
          bus_addr <= vec_r + 16'd1;
        end
        S_VEC_H: begin
          state <= S_FIN;
          lo_r  <= bus_rdata;
        end
        S_FIN: begin
          state   <= S_IDLE;
          pc_out  <= {bus_rdata, lo_r};
          pc_load <= 1'b1;
          sp_out  <= sp_r;
          sp_load <= (kind_r != K_RESET);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_addr,
  input logic        iflag,
  input logic        insn_start,
  input logic        rst_pend,
  input logic        brk_pend,
  input logic        pc_load
);
  a_r1_start_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(insn_start) || $past(rst_pend)));

  a_r2_inhibit_blocks_mask: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(iflag)) |-> ($past(rst_pend) || $past(brk_pend)));

  a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  a_r5_vector_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |=> (bus_rd && bus_addr == $past(bus_addr) + 16'd1));

  a_r6_push_descends: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> (bus_addr == $past(bus_addr) - 16'd1));

  a_r7_inhibit_held: assert property (@(posedge clk) disable iff (rst)
    busy |-> iflag);

  a_r8_load_at_end: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (!busy && $past(busy)));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .iflag(iflag), .insn_start(insn_start),
  .rst_pend(rst_pend), .brk_pend(brk_pend), .pc_load(pc_load)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int          NS   = 4;
  localparam logic [15:0] VTOP = 16'hFFFE;
  localparam int          KNONE = 0, KBRK = 1, KIRQ = 2, KRST = 3;

  // {ev[4], en[4], ifl, brk, kind[2], idx[2]}
  localparam logic [13:0] TBL [9] = '{
    {4'b0001, 4'b0001, 1'b0, 1'b0, 2'd2, 2'd0},
    {4'b0100, 4'b0100, 1'b0, 1'b0, 2'd2, 2'd2},
    {4'b0110, 4'b0110, 1'b0, 1'b0, 2'd2, 2'd1},
    {4'b1000, 4'b0000, 1'b0, 1'b0, 2'd0, 2'd0},
    {4'b1000, 4'b1000, 1'b1, 1'b0, 2'd0, 2'd0},
    {4'b0001, 4'b0001, 1'b1, 1'b1, 2'd1, 2'd0},
    {4'b0001, 4'b0001, 1'b0, 1'b1, 2'd1, 2'd0},
    {4'b0000, 4'b1111, 1'b0, 1'b0, 2'd0, 2'd0},
    {4'b1001, 4'b1000, 1'b0, 1'b0, 2'd2, 2'd3}
  };

  logic clk = 0, rst = 1;
  logic [NS-1:0] src_evt = '0, en_wdata = '0;
  logic en_we = 0, iflag_we = 0, iflag_wdata = 0, insn_start = 0, brk_strobe = 0;
  logic [15:0] pc_in = '0;
  logic [7:0]  ps_in = '0, sp_in = '0, bus_rdata = '0;
  logic [15:0] bus_addr, pc_out;
  logic bus_wr, bus_rd, busy, iflag, pc_load, sp_load;
  logic [7:0] bus_wdata, sp_out;

  always #4 clk = ~clk;

  irq_entry_seq #(.NUM_SRC(NS), .VEC_TOP(VTOP), .STACK_PAGE(8'h01)) u_dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .en_we(en_we), .en_wdata(en_wdata),
    .iflag_we(iflag_we), .iflag_wdata(iflag_wdata), .insn_start(insn_start),
    .brk_strobe(brk_strobe), .pc_in(pc_in), .ps_in(ps_in), .sp_in(sp_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .busy(busy), .iflag(iflag), .pc_out(pc_out),
    .pc_load(pc_load), .sp_out(sp_out), .sp_load(sp_load)
  );

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return a[7:0] + 8'h3C;
  endfunction

  always @(posedge clk) if (bus_rd) bus_rdata <= mem_byte(bus_addr);

  // bus monitor
  int busy_cnt, wr_cnt, rd_cnt, ld_cnt;
  logic [15:0] wr_a [3], rd_a [2];
  logic [7:0]  wr_d [3];
  int          wr_at [3], rd_at [2];
  logic [15:0] pc_got;
  logic [7:0]  sp_got;
  logic        spl_got;

  task automatic mon_clear();
    busy_cnt = 0; wr_cnt = 0; rd_cnt = 0; ld_cnt = 0;
    pc_got = '0; sp_got = '0; spl_got = 0;
  endtask

  always @(posedge clk) if (!rst) begin
    if (bus_wr && wr_cnt < 3) begin
      wr_a[wr_cnt] = bus_addr; wr_d[wr_cnt] = bus_wdata; wr_at[wr_cnt] = busy_cnt;
    end
    if (bus_wr) wr_cnt++;
    if (bus_rd && rd_cnt < 2) begin
      rd_a[rd_cnt] = bus_addr; rd_at[rd_cnt] = busy_cnt;
    end
    if (bus_rd) rd_cnt++;
    if (pc_load) begin
      ld_cnt++; pc_got = pc_out; sp_got = sp_out; spl_got = sp_load;
    end
    if (busy) busy_cnt++;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 100000", cyc);
      summary();
    end
  end

  function automatic logic [15:0] vec_of(int kind, int idx);
    if (kind == KRST) return VTOP;
    if (kind == KBRK) return VTOP - 16'd2;
    return VTOP - 16'd4 - 16'(2 * idx);
  endfunction

  task automatic check_entry(string tag, int kind, int idx);
    logic [15:0] v;
    if (kind == KNONE) begin
      chk({tag, " R2 busy"}, busy_cnt, 0);
      chk({tag, " R2 writes"}, wr_cnt, 0);
      chk({tag, " R2 loads"}, ld_cnt, 0);
      return;
    end
    v = vec_of(kind, idx);
    chk({tag, " R4/R9 vector lo addr"}, rd_a[0], v);
    chk({tag, " R5 vector hi addr"}, rd_a[1], v + 16'd1);
    chk({tag, " R8 pc"}, pc_got, {mem_byte(v + 16'd1), mem_byte(v)});
    chk({tag, " R8 one load"}, ld_cnt, 1);
    chk({tag, " R7 iflag"}, iflag, 1);
    if (kind == KRST) begin
      chk({tag, " R10 busy"}, busy_cnt, 5);
      chk({tag, " R10 writes"}, wr_cnt, 0);
      chk({tag, " R10 read slots"}, {rd_at[0][15:0], rd_at[1][15:0]}, {16'd2, 16'd3});
      chk({tag, " R10 sp_load"}, spl_got, 0);
    end else begin
      chk({tag, " R5 busy"}, busy_cnt, 8);
      chk({tag, " R5 read slots"}, {rd_at[0][15:0], rd_at[1][15:0]}, {16'd5, 16'd6});
      chk({tag, " R6 writes"}, wr_cnt, 3);
      for (int k = 0; k < 3; k++) begin
        chk({tag, " R6 push addr"}, wr_a[k], {8'h01, sp_in - 8'(k)});
        chk({tag, " R5 push slot"}, wr_at[k], 2 + k);
      end
      chk({tag, " R6 push data"}, {wr_d[0], wr_d[1], wr_d[2]}, {pc_in[15:8], pc_in[7:0], ps_in});
      chk({tag, " R6 sp_out"}, {spl_got, sp_got}, {1'b1, sp_in - 8'd3});
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk);
    mon_clear();
    rst = 0;
    repeat (10) @(negedge clk);
    check_entry("reset R10", KRST, 0);
  endtask

  task automatic setup(logic [3:0] ev, logic [3:0] en, logic ifl, logic brk);
    @(negedge clk); en_we = 1; en_wdata = en; iflag_we = 1; iflag_wdata = ifl;
    @(negedge clk); en_we = 0; iflag_we = 0; src_evt = ev; brk_strobe = brk;
    @(negedge clk); src_evt = '0; brk_strobe = 0;
  endtask

  task automatic boundary(bit mid_strobe);
    mon_clear();
    insn_start = 1;
    @(negedge clk); insn_start = 0;
    if (mid_strobe) begin
      repeat (3) @(negedge clk);
      insn_start = 1; brk_strobe = 1;
      @(negedge clk); insn_start = 0; brk_strobe = 0;
      repeat (12) @(negedge clk);
    end else begin
      repeat (12) @(negedge clk);
    end
  endtask

  task automatic clear_iflag();
    iflag_we = 1; iflag_wdata = 0;
    @(negedge clk); iflag_we = 0;
  endtask

  initial begin
    @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset iflag", iflag, 1);
    chk("R10 reset pc_load", pc_load, 0);
    mon_clear();
    rst = 0;
    repeat (10) @(negedge clk);
    check_entry("first R10", KRST, 0);

    foreach (TBL[i]) begin
      logic [13:0] e;
      e = TBL[i];
      do_reset();
      setup(e[13:10], e[9:6], e[5], e[4]);
      pc_in = 16'h1234 + 16'(i * 16'h0111);
      ps_in = 8'h20 + 8'(i);
      sp_in = 8'hF0 - 8'(i * 3);
      boundary(0);
      check_entry($sformatf("vec%0d R2/R3/R4", i), int'(e[3:2]), int'(e[1:0]));
    end

    // R1 and R11: pending request waits for a boundary, then is cleared
    do_reset();
    setup(4'b0001, 4'b1111, 1'b0, 1'b0);
    mon_clear();
    repeat (10) @(negedge clk);
    chk("R1 no boundary busy", busy_cnt, 0);
    boundary(0);
    check_entry("R1/R11 late take", KIRQ, 0);
    clear_iflag();
    boundary(0);
    check_entry("R7 cleared source", KNONE, 0);

    // R11: masked request persists; R7: serviced bit cleared, others kept
    do_reset();
    setup(4'b0011, 4'b0011, 1'b1, 1'b0);
    boundary(0);
    check_entry("R11 masked", KNONE, 0);
    clear_iflag();
    boundary(0);
    check_entry("R7 first", KIRQ, 0);
    clear_iflag();
    boundary(0);
    check_entry("R7 second", KIRQ, 1);

    // R1: strobes during a running entry do not chain
    do_reset();
    setup(4'b0100, 4'b0100, 1'b0, 1'b0);
    pc_in = 16'hBEEF; ps_in = 8'h5A; sp_in = 8'h03;
    boundary(1);
    check_entry("R1 no chain", KIRQ, 2);
    boundary(0);
    check_entry("R3 late break", KBRK, 0);

    summary();
  end
endmodule